// File: doc/BRIEF.md
# Transmit Packet Buffer Unpacker

This block sits between a 16-bit wide packet buffer RAM and the byte-wide transmit input of a MAC. When it is started with the word address of a stored transmit packet, it fetches the packet's byte-count word and its closing control word. From those two words it works out how many frame bytes to send and whether the MAC should add a frame check sequence. It then reads the frame data in ascending word order and streams it out one byte per cycle, low byte of each word first, under a valid/ready handshake.

A stored packet has a fixed layout. Word 0 is a reserved status word that is never read. Word 1 holds the byte count, whose least significant bit is ignored, so the count always covers a whole number of words. Frame data starts at byte offset 4. The last word carries the control byte in its upper half and, for odd-length frames, the final data byte in its lower half. The block sends every stored byte exactly as it is. It does not insert an address or interpret the length/type field. The decision on the check sequence combines a per-packet request bit with a global override input.

Top module: `tx_frame_unpacker`

## Requirements
- R1: Bit 0 of the stored byte count is forced to 0 before use. A stored count C and C+1 (C even) give identical behaviour, and an odd count of MAX_COUNT+1 is accepted as MAX_COUNT.
- R2: Data bytes begin at byte offset 4 (word base+2). They are sent in ascending address order, bits 7:0 of each word before bits 15:8, with every byte passed through unchanged. The status word and the count word are never sent.
- R3: The control byte is bits 15:8 of word base+C/2−1. Its ODD flag is bit 13 of that word. When ODD is set, exactly C−5 bytes are sent and the last one is bits 7:0 of the control word.
- R4: When ODD is clear, exactly C−6 bytes are sent and bits 7:0 of the control word are not sent. C=6 with ODD clear sends no byte and still ends with a done pulse.
- R5: crc_append_o equals (NOT crc_off_i) OR bit 12 of the control word. It is captured when the control word is read and is stable while any byte of that frame is valid.
- R6: A count (after R1) below 6 or above MAX_COUNT (default 2048) raises err_o for one cycle. No byte is sent, and no memory word beyond the count word is read.
- R7: tx_last_o is high only with the final byte of a frame. done_o pulses for one cycle, in the cycle after the final byte's handshake.
- R8: While tx_valid_o is high and tx_ready_i is low, tx_valid_o, tx_data_o and tx_last_o hold their values.
- R9: With tx_ready_i held high, once the first byte is valid a new byte is valid in every following cycle until the last byte.
- R10: start_i is ignored while busy_o is high. It neither changes the frame in progress nor starts another one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin unpacking the packet at base_addr_i (sampled while idle) |
| base_addr_i | input | ADDR_W | Word address of the packet's status word |
| crc_off_i | input | 1 | Global check-sequence disable; when set only the per-packet bit requests it |
| busy_o | output | 1 | A packet is being unpacked |
| done_o | output | 1 | One-cycle pulse when a packet has been fully sent |
| err_o | output | 1 | One-cycle pulse when a packet's byte count is out of range |
| mem_rd_en_o | output | 1 | Buffer read strobe; data returns on the following cycle |
| mem_rd_addr_o | output | ADDR_W | Buffer word address |
| mem_rd_data_i | input | 16 | Buffer read data |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_last_o | output | 1 | Output byte is the last of the frame |
| tx_ready_i | input | 1 | MAC accepts the byte |
| crc_append_o | output | 1 | MAC should append a check sequence to this frame |

## Verification
After the start edge the count word is requested one cycle later and arrives on the cycle after that. A range error therefore shows on err_o three edges after start. A zero-length packet shows done_o two edges after that. done_o follows the final handshake by exactly one edge. The bench drives and samples only on falling edges and holds the handshake decision for the next rising edge. From that it checks that done_o appears on the very next sample after the last accepted byte, and that a stalled byte is unchanged on the sample after the stall. Every count from 0 to 70 is swept with both ODD settings, with the check-sequence inputs rotated and several packets placed across the address wrap. Throttled and start-while-busy runs cover R8 and R10.

// File: rtl/tx_unpack_pkg.sv
package tx_unpack_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WORD_W    = 16;
  // bytes of header overhead: status word, count word, control byte pair
  localparam int unsigned HDR_BYTES = 6;
  // staging capacity between buffer reads and the output register
  localparam int unsigned BUF_BYTES = 6;
  localparam int unsigned FILL_W    = $clog2(BUF_BYTES + 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_CTRL   = 2'd2,
    ST_STREAM = 2'd3
  } unpack_state_e;

endpackage

// File: rtl/tx_unpack_hdr.sv
module tx_unpack_hdr
  import tx_unpack_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MAX_COUNT = 2048,
  parameter int unsigned ODD_BIT   = 5,
  parameter int unsigned CRC_BIT   = 4,
  parameter int unsigned NB_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              crc_off_i,
  input  logic              rvalid_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic              frame_end_i,
  output logic              busy_o,
  output logic              streaming_o,
  output logic              hdr_req_o,
  output logic [ADDR_W-1:0] hdr_addr_o,
  output logic              load_o,
  output logic [NB_W-1:0]   nbytes_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic              crc_append_o,
  output logic              done_o,
  output logic              err_o
);

  unpack_state_e     state_q;
  logic [ADDR_W-1:0] base_q;
  logic [WORD_W-1:0] cnt_q;
  logic              crc_q;
  logic              done_q;
  logic              err_q;

  logic [WORD_W-1:0] cnt_w;
  logic              cnt_bad;
  logic              odd_w;
  logic              crcb_w;
  logic [WORD_W-1:0] len_w;

  always_comb begin
    cnt_w   = rdata_i & ~WORD_W'(1);
    cnt_bad = (cnt_w < WORD_W'(HDR_BYTES)) || (cnt_w > WORD_W'(MAX_COUNT));
    odd_w   = rdata_i[BYTE_W + ODD_BIT];
    crcb_w  = rdata_i[BYTE_W + CRC_BIT];
    len_w   = cnt_q - WORD_W'(HDR_BYTES) + WORD_W'(odd_w);
  end

  always_comb begin
    hdr_req_o  = 1'b0;
    hdr_addr_o = '0;
    load_o     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          hdr_req_o  = 1'b1;
          hdr_addr_o = base_i + ADDR_W'(1);
        end
      end
      ST_COUNT: begin
        if (rvalid_i && !cnt_bad) begin
          hdr_req_o  = 1'b1;
          hdr_addr_o = base_q + ADDR_W'(cnt_w >> 1) - ADDR_W'(1);
        end
      end
      ST_CTRL: begin
        if (rvalid_i && (len_w != '0)) load_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign nbytes_o     = len_w[NB_W-1:0];
  assign first_addr_o = base_q + ADDR_W'(2);
  assign busy_o       = (state_q != ST_IDLE);
  assign streaming_o  = (state_q == ST_STREAM);
  assign crc_append_o = crc_q;
  assign done_o       = done_q;
  assign err_o        = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      crc_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q  <= base_i;
            state_q <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (rvalid_i) begin
            if (cnt_bad) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q   <= cnt_w;
              state_q <= ST_CTRL;
            end
          end
        end
        ST_CTRL: begin
          if (rvalid_i) begin
            crc_q <= !crc_off_i || crcb_w;
            if (len_w == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_STREAM;
            end
          end
        end
        ST_STREAM: begin
          if (frame_end_i) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: an aborted packet never also reports completion
  a_r6_err_excludes_done: assert property (@(posedge clk) disable iff (rst)
    !(err_q && done_q));

  // R7: completion and error are single-cycle pulses
  a_r7_done_is_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/tx_unpack_fetch.sv
module tx_unpack_fetch
  import tx_unpack_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NB_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_req_i,
  input  logic [ADDR_W-1:0] hdr_addr_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic              stream_i,
  input  logic [FILL_W-1:0] fill_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  output logic              rvalid_o,
  output logic              push_o,
  output logic              push_two_o
);

  localparam int unsigned PROJ_W = FILL_W + 2;

  logic              rd_en_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rvalid_q;
  logic [ADDR_W-1:0] next_addr_q;
  logic [NB_W-1:0]   words_left_q;
  logic [NB_W-1:0]   push_left_q;

  logic [PROJ_W-1:0] proj;
  logic              issue;
  logic [NB_W-1:0]   words_init;

  always_comb begin
    // bytes held plus bytes already requested but not yet landed
    proj = PROJ_W'(fill_i)
         + (rd_en_q  ? PROJ_W'(2) : PROJ_W'(0))
         + (rvalid_q ? PROJ_W'(2) : PROJ_W'(0));
    issue = stream_i && (words_left_q != '0) &&
            (proj <= PROJ_W'(BUF_BYTES - 2));
    words_init = NB_W'(({1'b0, nbytes_i} + (NB_W + 1)'(1)) >> 1);
  end

  assign mem_rd_en_o   = rd_en_q;
  assign mem_rd_addr_o = addr_q;
  assign rvalid_o      = rvalid_q;
  assign push_o        = stream_i && rvalid_q;
  assign push_two_o    = (push_left_q >= NB_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_q      <= 1'b0;
      addr_q       <= '0;
      rvalid_q     <= 1'b0;
      next_addr_q  <= '0;
      words_left_q <= '0;
      push_left_q  <= '0;
    end else begin
      rd_en_q  <= hdr_req_i || issue;
      rvalid_q <= rd_en_q;
      if (hdr_req_i) begin
        addr_q <= hdr_addr_i;
      end else if (issue) begin
        addr_q <= next_addr_q;
      end
      if (load_i) begin
        next_addr_q  <= first_addr_i;
        words_left_q <= words_init;
        push_left_q  <= nbytes_i;
      end else begin
        if (issue) begin
          next_addr_q  <= next_addr_q + ADDR_W'(1);
          words_left_q <= words_left_q - NB_W'(1);
        end
        if (push_o) begin
          push_left_q <= push_left_q - (push_two_o ? NB_W'(2) : NB_W'(1));
        end
      end
    end
  end

  // R3: a word never lands after all of the frame's bytes were delivered
  a_r3_no_push_past_end: assert property (@(posedge clk) disable iff (rst)
    push_o |-> (push_left_q != '0));

endmodule

// File: rtl/tx_unpack_bytebuf.sv
module tx_unpack_bytebuf
  import tx_unpack_pkg::*;
#(
  parameter int unsigned NB_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic              push_i,
  input  logic              push_two_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tx_ready_i,
  output logic [FILL_W-1:0] fill_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_last_o,
  output logic              frame_end_o
);

  localparam int unsigned STASH_W = BUF_BYTES * BYTE_W;

  logic [STASH_W-1:0] stash_q;
  logic [FILL_W-1:0]  fill_q;
  logic [NB_W-1:0]    out_left_q;
  logic               tx_valid_q;
  logic [BYTE_W-1:0]  tx_data_q;
  logic               tx_last_q;

  logic               adv;
  logic               pop;
  logic [STASH_W-1:0] stash_pop;
  logic [STASH_W-1:0] stash_n;
  logic [FILL_W-1:0]  fill_pop;
  logic [FILL_W-1:0]  fill_n;
  logic [WORD_W-1:0]  word_m;

  always_comb begin
    adv       = !tx_valid_q || tx_ready_i;
    pop       = adv && (fill_q != '0);
    stash_pop = pop ? (stash_q >> BYTE_W) : stash_q;
    fill_pop  = fill_q - FILL_W'(pop);
    word_m    = push_two_i ? word_i : {{BYTE_W{1'b0}}, word_i[BYTE_W-1:0]};
    stash_n   = stash_pop;
    fill_n    = fill_pop;
    if (push_i) begin
      stash_n = stash_pop | (STASH_W'(word_m) << {fill_pop, 3'b000});
      fill_n  = fill_pop + (push_two_i ? FILL_W'(2) : FILL_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stash_q    <= '0;
      fill_q     <= '0;
      out_left_q <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      tx_last_q  <= 1'b0;
    end else begin
      stash_q <= stash_n;
      fill_q  <= fill_n;
      if (load_i) begin
        out_left_q <= nbytes_i;
      end else if (pop) begin
        out_left_q <= out_left_q - NB_W'(1);
      end
      if (adv) begin
        tx_valid_q <= pop;
      end
      if (pop) begin
        tx_data_q <= stash_q[BYTE_W-1:0];
        tx_last_q <= (out_left_q == NB_W'(1));
      end
    end
  end

  assign fill_o      = fill_q;
  assign tx_valid_o  = tx_valid_q;
  assign tx_data_o   = tx_data_q;
  assign tx_last_o   = tx_last_q;
  assign frame_end_o = tx_valid_q && tx_ready_i && tx_last_q;

  // R8: a refused byte stays presented unchanged
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_q && !tx_ready_i) |=>
      (tx_valid_q && $stable(tx_data_q) && $stable(tx_last_q)));

  // R9: read throttling never lets the staging store overflow
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FILL_W'(BUF_BYTES));

  // R7: once the final byte is out, nothing of that frame remains to emit
  a_r7_last_drains: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_q && tx_last_q) |-> (out_left_q == '0));

endmodule

// File: rtl/tx_frame_unpacker.sv
module tx_frame_unpacker
  import tx_unpack_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MAX_COUNT = 2048,
  parameter int unsigned ODD_BIT   = 5,
  parameter int unsigned CRC_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              crc_off_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [15:0]       mem_rd_data_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic              crc_append_o
);

  localparam int unsigned NB_W = $clog2(MAX_COUNT + 1);

  logic              streaming;
  logic              hdr_req;
  logic [ADDR_W-1:0] hdr_addr;
  logic              load;
  logic [NB_W-1:0]   nbytes;
  logic [ADDR_W-1:0] first_addr;
  logic              rvalid;
  logic              push;
  logic              push_two;
  logic [FILL_W-1:0] fill;
  logic              frame_end;

  tx_unpack_hdr #(
    .ADDR_W   (ADDR_W),
    .MAX_COUNT(MAX_COUNT),
    .ODD_BIT  (ODD_BIT),
    .CRC_BIT  (CRC_BIT),
    .NB_W     (NB_W)
  ) u_hdr (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .base_i      (base_addr_i),
    .crc_off_i   (crc_off_i),
    .rvalid_i    (rvalid),
    .rdata_i     (mem_rd_data_i),
    .frame_end_i (frame_end),
    .busy_o      (busy_o),
    .streaming_o (streaming),
    .hdr_req_o   (hdr_req),
    .hdr_addr_o  (hdr_addr),
    .load_o      (load),
    .nbytes_o    (nbytes),
    .first_addr_o(first_addr),
    .crc_append_o(crc_append_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  tx_unpack_fetch #(
    .ADDR_W(ADDR_W),
    .NB_W  (NB_W)
  ) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .hdr_req_i    (hdr_req),
    .hdr_addr_i   (hdr_addr),
    .load_i       (load),
    .first_addr_i (first_addr),
    .nbytes_i     (nbytes),
    .stream_i     (streaming),
    .fill_i       (fill),
    .mem_rd_en_o  (mem_rd_en_o),
    .mem_rd_addr_o(mem_rd_addr_o),
    .rvalid_o     (rvalid),
    .push_o       (push),
    .push_two_o   (push_two)
  );

  tx_unpack_bytebuf #(
    .NB_W(NB_W)
  ) u_bytebuf (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .nbytes_i   (nbytes),
    .push_i     (push),
    .push_two_i (push_two),
    .word_i     (mem_rd_data_i),
    .tx_ready_i (tx_ready_i),
    .fill_o     (fill),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o),
    .frame_end_o(frame_end)
  );

  // R5: the check-sequence decision does not move under a presented byte
  a_r5_crc_steady: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> $stable(crc_append_o));

  // R7: accepting the final byte is followed by the completion pulse
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && tx_ready_i && tx_last_o) |=> done_o);

  // R10: bytes only flow while a packet is in progress
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_rd_en_o || $past(start_i));

endmodule

// File: tb/test_tx_frame_unpacker.sv
module test_tx_frame_unpacker;

  localparam int AW    = 7;
  localparam int MAXC  = 64;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic          crc_off_i = 1'b0;
  logic          busy_o, done_o, err_o;
  logic          mem_rd_en_o;
  logic [AW-1:0] mem_rd_addr_o;
  logic [15:0]   mem_rd_data_i;
  logic          tx_valid_o;
  logic [7:0]    tx_data_o;
  logic          tx_last_o;
  logic          tx_ready_i = 1'b1;
  logic          crc_append_o;

  int total = 0;
  int bad   = 0;
  int reads = 0;

  logic [15:0] mem [0:DEPTH-1];

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en_o) begin
      mem_rd_data_i <= mem[mem_rd_addr_o];
      reads <= reads + 1;
    end
  end

  tx_frame_unpacker #(
    .ADDR_W   (AW),
    .MAX_COUNT(MAXC)
  ) i_tx_frame_unpacker (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .base_addr_i  (base_addr_i),
    .crc_off_i    (crc_off_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .mem_rd_en_o  (mem_rd_en_o),
    .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_data_i(mem_rd_data_i),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o),
    .tx_last_o    (tx_last_o),
    .tx_ready_i   (tx_ready_i),
    .crc_append_o (crc_append_o)
  );

  function automatic logic [7:0] pat(int base, int off);
    return 8'((base * 5 + off * 3 + 7) & 255);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build(int base, int craw, bit odd, bit crcb);
    int eff;
    eff = craw & ~1;
    mem[base % DEPTH]       = 16'hC3A5;
    mem[(base + 1) % DEPTH] = 16'(craw);
    if (eff >= 6 && eff <= MAXC) begin
      for (int w = 2; w < eff / 2 - 1; w++)
        mem[(base + w) % DEPTH] = {pat(base, 2 * w + 1), pat(base, 2 * w)};
      mem[(base + eff / 2 - 1) % DEPTH] =
        {8'h81 | {2'b00, odd, crcb, 4'b0000}, pat(base, eff - 2)};
    end
  endtask

  // mode 0: ready always high, 1: throttled ready, 2: start pulsed mid-frame
  task automatic run_frame(int base, int craw, bit odd, bit crcb, bit crcoff, int mode);
    int eff, n, idx, r0, last_k, done_k, gap, stall_bad, data_bad, last_bad, crc_bad;
    int first_act, first_exp;
    bit ok, fin, errseen, doneseen, seen_valid, stalled, rdy, crc_seen, expcrc;
    logic [7:0] pdata;
    logic plast;
    eff = craw & ~1;
    ok = (eff >= 6) && (eff <= MAXC);
    n = ok ? eff - 6 + int'(odd) : 0;
    expcrc = !crcoff || crcb;
    build(base, craw, odd, crcb);
    idx = 0; last_k = -10; done_k = -20; gap = 0; stall_bad = 0;
    data_bad = 0; last_bad = 0; crc_bad = 0; first_act = 0; first_exp = 0;
    fin = 0; errseen = 0; doneseen = 0; seen_valid = 0; stalled = 0; crc_seen = 0;
    pdata = '0; plast = 1'b0;
    @(negedge clk);
    r0 = reads;
    base_addr_i = AW'(base);
    crc_off_i = crcoff;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 600 && !fin; k++) begin
      if (done_o) begin doneseen = 1; done_k = k; crc_seen = crc_append_o; fin = 1; end
      if (err_o) begin errseen = 1; fin = 1; end
      if (!fin) begin
        if (stalled && (!tx_valid_o || tx_data_o !== pdata || tx_last_o !== plast))
          stall_bad++;
        rdy = (mode == 1) ? (((k * 7 + base) % 3) != 0) : 1'b1;
        start_i = (mode == 2 && k == 3);
        if (mode == 2 && k == 3) base_addr_i = AW'((base + 40) % DEPTH);
        tx_ready_i = rdy;
        if (tx_valid_o) begin
          seen_valid = 1;
          if (crc_append_o !== expcrc) crc_bad++;
          stalled = !rdy;
          pdata = tx_data_o;
          plast = tx_last_o;
          if (rdy) begin
            if (tx_data_o !== pat(base, 4 + idx)) begin
              if (data_bad == 0) begin first_act = tx_data_o; first_exp = pat(base, 4 + idx); end
              data_bad++;
            end
            if (tx_last_o !== (idx == n - 1)) last_bad++;
            if (tx_last_o) last_k = k;
            idx++;
          end
        end else begin
          stalled = 0;
          if (seen_valid && idx < n) gap++;
        end
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    tx_ready_i = 1'b1;
    check(fin, "R7", "frame ended before timeout", fin, 1);
    if (ok) begin
      check(!errseen, "R6", "no error on valid count", errseen, 0);
      check(doneseen, "R7", "done pulse seen", doneseen, 1);
      check(idx == n, odd ? "R3" : "R4", "bytes sent", idx, n);
      if (craw % 2 == 1) check(idx == n, "R1", "odd stored count byte total", idx, n);
      check(data_bad == 0, "R2", "byte content/order", first_act, first_exp);
      check(last_bad == 0, "R7", "last flag placement errors", last_bad, 0);
      if (n > 0) check(done_k == last_k + 1, "R7", "done one cycle after final handshake", done_k - last_k, 1);
      check(crc_seen == expcrc && crc_bad == 0, "R5", "crc append decision", crc_seen, expcrc);
      if (mode == 0) check(gap == 0, "R9", "gap cycles in stream", gap, 0);
      if (mode == 1) check(stall_bad == 0, "R8", "stall hold violations", stall_bad, 0);
    end else begin
      check(errseen, "R6", "error pulse on bad count", errseen, 1);
      check(idx == 0, "R6", "bytes sent on bad count", idx, 0);
      check(reads - r0 == 1, "R6", "words read on bad count", reads - r0, 1);
    end
    if (mode == 2) begin
      r0 = reads;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (busy_o || tx_valid_o) begin
          check(0, "R10", "activity after ignored start", 1, 0);
          break;
        end
      end
      check(reads == r0, "R10", "reads after ignored start", reads - r0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!tx_valid_o && !busy_o && !mem_rd_en_o && !done_o && !err_o,
          "R7", "reset state quiet", int'(tx_valid_o) + int'(busy_o) + int'(mem_rd_en_o), 0);
    check(crc_append_o == 1'b0, "R5", "reset crc decision", crc_append_o, 0);

    // full sweep of counts with both ODD settings
    for (int c = 0; c <= 70; c++) begin
      for (int o = 0; o < 2; o++) begin
        run_frame((c * 11 + o * 37) % DEPTH, c, o[0], (c % 3) == 0,
                  ((c >> 1) % 2) == 1, (c % 4 == 1) ? 1 : 0);
      end
    end

    // every crc input combination on one length
    for (int m = 0; m < 4; m++) run_frame(90, 20, m[0], m[1], m[0] ^ m[1] ? 1'b1 : 1'b0, 0);
    for (int m = 0; m < 4; m++) run_frame(10, 21, 1'b0, m[0], m[1], 0);

    // long throttled frames, including one that wraps the address space
    run_frame(120, 64, 1'b1, 1'b1, 1'b1, 1);
    run_frame(5, 65, 1'b0, 1'b0, 1'b0, 1);

    // start while busy
    run_frame(30, 40, 1'b1, 1'b0, 1'b1, 2);
    run_frame(70, 30, 1'b0, 1'b1, 1'b0, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule